// File: doc/BRIEF.md
# Coprocessor Bus Acknowledge Responder

This block is the slave-side handshake of a coprocessor that sits on an asynchronous, strobe-based microprocessor bus. It watches the address strobe and data strobe (both active low), the read/write line, address bit 4 and a strapped port width. It answers each bus cycle on two active-low acknowledge lines. Each line has its own output enable, so the pads can float between cycles. The acknowledge pattern tells the host how wide the transfer is and where on the bus the valid data sits.

Both strobes pass through a two-flop synchronizer. Until the internal core raises its ready flag, the block holds both acknowledge lines driven high, and the host inserts wait states. When ready arrives, the block drives the acknowledge code for the configured width. Every register narrower than 32 bits is presented on the upper half of the data bus, so no lane multiplexer is needed. When either strobe rises, the block drives both lines inactive for exactly one clock, then releases them to high impedance.

A raw active-high reset is filtered. Only a pulse held for at least three consecutive clock edges clears the block. Shorter pulses are ignored.

Top module: `copro_ack_responder`

## Requirements
- R1: With port_sz = 2'b10 or 2'b11 (32-bit) and a4 = 1, the acknowledge phase drives dsack_n = 2'b00 (bit 1 is the upper line, bit 0 the lower line). On a read, dbus_out equals core_data in full.
- R2: With a 32-bit port and a4 = 0, the acknowledge phase drives dsack_n = 2'b01. On a read, dbus_out is {core_data[15:0], 16'h0000}.
- R3: With port_sz = 2'b01 (16-bit), the acknowledge phase drives dsack_n = 2'b01 whatever the value of a4. Read data is placed as {core_data[15:0], 16'h0000}.
- R4: With port_sz = 2'b00 (8-bit), the acknowledge phase drives dsack_n = 2'b10. Read data is placed as {core_data[15:0], 16'h0000}.
- R5: While core_ready is low inside a bus cycle, dsack_oe = 2'b11 and dsack_n = 2'b11 (wait states). The acknowledge code appears on the clock edge after core_ready is seen high.
- R6: Once either strobe is seen high in a cycle, the block drives dsack_oe = 2'b11 and dsack_n = 2'b11 for exactly one clock. On the next edge dsack_oe becomes 2'b00.
- R7: Outside a bus cycle, and while the filtered reset is active, dsack_oe = 2'b00 and dbus_oe = 0.
- R8: A pulse on rst lasting two or fewer clock edges has no effect: an acknowledge in progress continues. A pulse lasting three or more edges returns the block to idle, with the enables low.
- R9: The block enables the acknowledge lines (in the wait phase) on the third clock edge after both strobes are low. The acknowledge code comes no earlier than one clock after that.
- R10: dbus_oe is high only during the acknowledge phase of a read cycle (rw = 1). It stays low on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Raw active-high reset; filtered to at least three edges |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| rw | input | 1 | 1 = host reads, 0 = host writes |
| a4 | input | 1 | Address bit 4; selects a 32-bit or 16-bit register on a 32-bit port |
| port_sz | input | 2 | Port width: 00 = 8, 01 = 16, 1x = 32 bits |
| core_ready | input | 1 | Internal data ready; low inserts wait states |
| core_data | input | 32 | Register read data from the core |
| dsack_n | output | 2 | Acknowledge line values, active low ([1] upper, [0] lower) |
| dsack_oe | output | 2 | Output enables of the two acknowledge lines |
| dbus_out | output | 32 | Lane-steered read data |
| dbus_oe | output | 1 | Data bus output enable |

## Verification
The timing of every result follows from the register chain. The enables come up three edges after the strobes fall, with two synchronizer flops plus the state register. The acknowledge code comes one edge after ready is seen. The negate phase starts three edges after a strobe rises, and the release follows one edge later. Each task drives its inputs one nanosecond after an edge and counts exactly those edges before sampling. Every sample is taken one nanosecond after an edge, so the check lands on the cycle the requirement names and not merely somewhere in a window.

// File: rtl/copro_ack_pkg.sv
package copro_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_NEG  = 2'd3
    } bus_state_t;

    typedef struct packed {
        logic [1:0] code;      // active-low {upper, lower}
        logic       short_reg; // data steered to upper half
    } ack_ctl_t;

    localparam logic [1:0] ACK_FULL  = 2'b00;
    localparam logic [1:0] ACK_UPPER = 2'b01;
    localparam logic [1:0] ACK_BYTE  = 2'b10;
    localparam logic [1:0] ACK_NONE  = 2'b11;

    function automatic ack_ctl_t decode_ack(input logic [1:0] port_sz, input logic a4);
        ack_ctl_t c;
        if (port_sz[1]) begin
            c.code      = a4 ? ACK_FULL : ACK_UPPER;
            c.short_reg = ~a4;
        end else if (port_sz[0]) begin
            c.code      = ACK_UPPER;
            c.short_reg = 1'b1;
        end else begin
            c.code      = ACK_BYTE;
            c.short_reg = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/cab_sync.sv
module cab_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (srst) chain[s] <= '1;
                    else      chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (srst) chain[s] <= '1;
                    else      chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cab_rst_filter.sv
module cab_rst_filter #(
    parameter int MIN_EDGES = 3
) (
    input  logic clk,
    input  logic rst_raw,
    output logic rst_eff
);
    localparam int CW = $clog2(MIN_EDGES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_EDGES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_raw)            cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign rst_eff = rst_raw && (cnt_q == LIMIT);
endmodule

// File: rtl/cab_fsm.sv
module cab_fsm
    import copro_ack_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  logic       as_s,
    input  logic       ds_s,
    input  logic       ready,
    input  logic [1:0] port_sz,
    input  logic       a4,
    output bus_state_t state,
    output ack_ctl_t   ctl
);
    bus_state_t state_d;
    logic       strobes_low;
    logic       strobe_up;

    assign strobes_low = !as_s && !ds_s;
    assign strobe_up   = as_s || ds_s;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: if (strobes_low) state_d = ST_WAIT;
            ST_WAIT: begin
                if (strobe_up)  state_d = ST_NEG;
                else if (ready) state_d = ST_ACK;
            end
            ST_ACK:  if (strobe_up) state_d = ST_NEG;
            ST_NEG:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state <= ST_IDLE;
            ctl   <= '{code: ACK_NONE, short_reg: 1'b0};
        end else begin
            state <= state_d;
            if (state == ST_IDLE && strobes_low) ctl <= decode_ack(port_sz, a4);
        end
    end
endmodule

// File: rtl/copro_ack_responder.sv
module copro_ack_responder
    import copro_ack_pkg::*;
#(
    parameter int DW         = 32,
    parameter int SYNC_STAGE = 2,
    parameter int RST_EDGES  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          as_n,
    input  logic          ds_n,
    input  logic          rw,
    input  logic          a4,
    input  logic [1:0]    port_sz,
    input  logic          core_ready,
    input  logic [DW-1:0] core_data,
    output logic [1:0]    dsack_n,
    output logic [1:0]    dsack_oe,
    output logic [DW-1:0] dbus_out,
    output logic          dbus_oe
);
    localparam int HW = DW / 2;

    logic       rst_eff;
    logic [1:0] strobe_s;
    bus_state_t state_q;
    ack_ctl_t   ctl_q;
    logic       rw_q;

    cab_rst_filter #(.MIN_EDGES(RST_EDGES)) u_rflt (
        .clk(clk), .rst_raw(rst), .rst_eff(rst_eff)
    );

    cab_sync #(.W(2), .STAGES(SYNC_STAGE)) u_sync (
        .clk(clk), .srst(rst_eff), .d({as_n, ds_n}), .q(strobe_s)
    );

    cab_fsm u_fsm (
        .clk(clk), .srst(rst_eff),
        .as_s(strobe_s[1]), .ds_s(strobe_s[0]),
        .ready(core_ready), .port_sz(port_sz), .a4(a4),
        .state(state_q), .ctl(ctl_q)
    );

    always_ff @(posedge clk) begin
        if (rst_eff)                 rw_q <= 1'b0;
        else if (state_q == ST_IDLE) rw_q <= rw;
    end

    always_comb begin
        dsack_oe = (state_q == ST_IDLE) ? 2'b00 : 2'b11;
        dsack_n  = (state_q == ST_ACK) ? ctl_q.code : ACK_NONE;
        dbus_oe  = (state_q == ST_ACK) && rw_q;
        dbus_out = ctl_q.short_reg ? {core_data[HW-1:0], {HW{1'b0}}} : core_data;
    end
endmodule

// File: rtl/cab_checker.sv
module cab_checker
    import copro_ack_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input bus_state_t state_q,
    input logic [1:0] dsack_n,
    input logic [1:0] dsack_oe,
    input logic       dbus_oe,
    input logic       rw
);
    a_r5_wait_lines_high: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_WAIT |-> (dsack_oe == 2'b11 && dsack_n == 2'b11));

    a_r6_negate_one_cycle: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_NEG |=> (dsack_oe == 2'b00 && state_q == ST_IDLE));

    a_r7_idle_released: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_IDLE |-> (dsack_oe == 2'b00 && !dbus_oe));

    a_r9_no_direct_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_ACK) |-> $past(state_q) == ST_WAIT);

    a_r1_code_stable: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACK && $past(state_q) == ST_ACK) |-> $stable(dsack_n));

    a_r10_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        $rose(dbus_oe) |-> $past(rw));

    a_r6_oe_paired: assert property (@(posedge clk) disable iff (rst)
        (dsack_oe == 2'b00 || dsack_oe == 2'b11));
endmodule

bind copro_ack_responder cab_checker u_chk (
    .clk(clk), .rst(rst), .state_q(state_q), .dsack_n(dsack_n),
    .dsack_oe(dsack_oe), .dbus_oe(dbus_oe), .rw(rw)
);

// File: tb/sim_copro_ack_responder.sv
`timescale 1ns/1ps
module sim_copro_ack_responder;
    logic        clk = 1'b0;
    logic        rst, as_n, ds_n, rw, a4, core_ready;
    logic [1:0]  port_sz;
    logic [31:0] core_data;
    logic [1:0]  dsack_n, dsack_oe;
    logic [31:0] dbus_out;
    logic        dbus_oe;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    copro_ack_responder u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .rw(rw), .a4(a4),
        .port_sz(port_sz), .core_ready(core_ready), .core_data(core_data),
        .dsack_n(dsack_n), .dsack_oe(dsack_oe), .dbus_out(dbus_out), .dbus_oe(dbus_oe)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Complete cycle with ready already high; checks wait, ack, negate, release.
    task automatic full_cycle(input string req, input logic [1:0] ps, input logic a,
                              input logic r, input logic [31:0] d,
                              input logic [1:0] exp_code, input logic [31:0] exp_data);
        port_sz = ps; a4 = a; rw = r; core_data = d; core_ready = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        tick(2);
        check("R9 no enable before third edge", {30'd0, dsack_oe}, 32'd0);
        tick(1);
        check("R9 wait phase enables", {28'd0, dsack_oe, dsack_n}, 32'hF);
        tick(1);
        check({req, " ack code"}, {30'd0, dsack_n}, {30'd0, exp_code});
        check("R1 oe in ack", {30'd0, dsack_oe}, 32'd3);
        check("R10 dbus_oe", {31'd0, dbus_oe}, {31'd0, r});
        if (r) check({req, " data lanes"}, dbus_out, exp_data);
        as_n = 1'b1; ds_n = 1'b1;
        tick(2);
        check({req, " code held until strobe seen"}, {30'd0, dsack_n}, {30'd0, exp_code});
        tick(1);
        check("R6 negate phase", {28'd0, dsack_oe, dsack_n}, 32'hF);
        check("R10 dbus off in negate", {31'd0, dbus_oe}, 32'd0);
        tick(1);
        check("R6 released", {30'd0, dsack_oe}, 32'd0);
        tick(1);
    endtask

    task automatic t_reset_state();
        check("R7 oe low in reset", {30'd0, dsack_oe}, 32'd0);
        check("R7 dbus_oe low in reset", {31'd0, dbus_oe}, 32'd0);
        rst = 1'b0;
        tick(2);
        check("R7 idle released", {30'd0, dsack_oe}, 32'd0);
    endtask

    task automatic t_widths();
        full_cycle("R1", 2'b10, 1'b1, 1'b1, 32'hDEADBEEF, 2'b00, 32'hDEADBEEF);
        full_cycle("R1", 2'b11, 1'b1, 1'b1, 32'h12345678, 2'b00, 32'h12345678);
        full_cycle("R2", 2'b10, 1'b0, 1'b1, 32'hCAFE5A5A, 2'b01, 32'h5A5A0000);
        full_cycle("R3", 2'b01, 1'b0, 1'b1, 32'h0000ABCD, 2'b01, 32'hABCD0000);
        full_cycle("R3", 2'b01, 1'b1, 1'b1, 32'h11112222, 2'b01, 32'h22220000);
        full_cycle("R4", 2'b00, 1'b1, 1'b1, 32'h99887766, 2'b10, 32'h77660000);
        full_cycle("R10 write", 2'b10, 1'b1, 1'b0, 32'h0, 2'b00, 32'h0);
    endtask

    task automatic t_wait_states();
        port_sz = 2'b10; a4 = 1'b1; rw = 1'b1; core_ready = 1'b0; core_data = 32'h1;
        as_n = 1'b0; ds_n = 1'b0;
        tick(3);
        for (int i = 0; i < 5; i++) begin
            check("R5 wait held", {28'd0, dsack_oe, dsack_n}, 32'hF);
            tick(1);
        end
        core_ready = 1'b1;
        tick(1);
        check("R5 ack after ready", {30'd0, dsack_n}, 32'd0);
        as_n = 1'b1; ds_n = 1'b1; core_ready = 1'b0;
        tick(5);
        // strobe released while never ready
        as_n = 1'b0; ds_n = 1'b0;
        tick(4);
        ds_n = 1'b1;
        tick(3);
        check("R6 negate without ack", {28'd0, dsack_oe, dsack_n}, 32'hF);
        tick(1);
        check("R6 release without ack", {30'd0, dsack_oe}, 32'd0);
        as_n = 1'b1;
        tick(3);
    endtask

    task automatic t_reset_filter();
        port_sz = 2'b01; a4 = 1'b0; rw = 1'b1; core_ready = 1'b1;
        as_n = 1'b0; ds_n = 1'b0;
        tick(4);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        check("R8 short pulse ignored", {28'd0, dsack_oe, dsack_n}, 32'hD);
        rst = 1'b1;
        tick(3);
        check("R8 long pulse clears", {30'd0, dsack_oe}, 32'd0);
        as_n = 1'b1; ds_n = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(3);
        check("R7 idle after reset", {30'd0, dsack_oe}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1; a4 = 1'b0;
        port_sz = 2'b10; core_ready = 1'b0; core_data = '0;
        tick(5);
        t_reset_state();
        t_widths();
        t_wait_states();
        t_reset_filter();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule